// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Two-Level Operation Decode

This block is the execution unit of a small multicycle integer core. It takes two 32-bit operands and returns their bitwise AND, bitwise OR, sum, difference, or a signed less-than result. Alongside the result it gives a zero indication and a signed overflow indication. The block is purely combinational. The controller presents operands and control on one cycle and registers the outputs at the next edge.

The operation is chosen in two steps. The main controller supplies a 2-bit operation class. Class 00 is for load and store address generation and always adds. Class 01 is for equality branches and always subtracts, so the zero output answers the comparison. Class 10, and also class 11, hands the choice to the 6-bit function field of a register-format instruction.

The decoder reduces this to a 3-bit internal code. The top bit of that code both inverts the second operand and supplies the adder's carry-in. Subtract and less-than therefore share the single ripple adder with add. A function field that the decoder does not recognise raises an error output and falls back to add.

Top module: `arith_logic_unit`

## Requirements
- R1: With op_class 00 the result is opnd_a + opnd_b modulo 2^32, whatever func_code holds, and bad_func is 0.
- R2: With op_class 01 the result is opnd_a - opnd_b modulo 2^32, whatever func_code holds, and bad_func is 0; equal operands therefore give zero_flag 1.
- R3: With op_class 10 or 11, func_code 0x20 selects add, 0x22 subtract, 0x24 bitwise AND, 0x25 bitwise OR and 0x2A signed set-less-than.
- R4: Add and subtract wrap modulo 2^32, including carry and borrow out of bit 31.
- R5: Set-less-than returns 1 in bit 0 when opnd_a is less than opnd_b as two's-complement numbers, correct also when the difference overflows, and 0 in bits 31 to 1.
- R6: zero_flag is 1 exactly when all 32 result bits are 0.
- R7: ovf_flag is 1 for add when both operands share a sign that the result does not have, and for subtract when the operands differ in sign and the result sign differs from opnd_a; it is 0 for AND, OR and set-less-than.
- R8: With op_class 10 or 11 and any func_code other than the five in R3, bad_func is 1 and the block behaves as add (result and ovf_flag as for add); bad_func is 0 for the five listed codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main controller: 00 add, 01 subtract, 1x decode func_code |
| func_code | input | 6 | Function field of a register-format instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |
| bad_func | output | 1 | Unrecognised function field under class 1x |

## Verification
The block holds no state, so any fault in the decoder or in the carry chain shows up at the ports in the same cycle the inputs are applied. A decoder that picks the wrong code shows a sum where an AND was expected, or a difference in place of a sum. Those values differ for almost any operand pair. A wrong carry-in or a wrong operand inversion moves the result by one or gives its complement. The most telling cases are those near the sign boundary. A broken overflow correction gives the wrong less-than answer only when the operands straddle the sign boundary. The bench therefore pairs the most negative and most positive values in set-less-than and in the overflow checks.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
// Package alu_pkg
// Shared widths, operation-code encodings and class encodings for the ALU.
// Assumes the 3-bit code layout: bit 2 = invert B and carry in,
// bits 1:0 = output select (AND, OR, sum, less).
package alu_pkg;

    parameter int FUNC_W  = 6;
    parameter int CLASS_W = 2;
    parameter int CODE_W  = 3;
    parameter int SEL_W   = 2;

    typedef enum logic [CODE_W-1:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_code_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEM   = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_RFMT  = 2'b10,
        CLS_RALT  = 2'b11
    } op_class_e;

    localparam logic [FUNC_W-1:0] FN_ADD = 6'h20;
    localparam logic [FUNC_W-1:0] FN_SUB = 6'h22;
    localparam logic [FUNC_W-1:0] FN_AND = 6'h24;
    localparam logic [FUNC_W-1:0] FN_OR  = 6'h25;
    localparam logic [FUNC_W-1:0] FN_SLT = 6'h2A;

    localparam logic [SEL_W-1:0] SEL_AND  = 2'b00;
    localparam logic [SEL_W-1:0] SEL_OR   = 2'b01;
    localparam logic [SEL_W-1:0] SEL_SUM  = 2'b10;
    localparam logic [SEL_W-1:0] SEL_LESS = 2'b11;

endpackage

// File: rtl/alu_op_decoder.sv
`timescale 1ns/1ps
// Module alu_op_decoder
// Second-level control: turns the operation class and the function field
// into the 3-bit ALU code. Classes 00 and 01 ignore the function field.
// Classes 10 and 11 both decode it. An unknown field gives add and bad_func.
// Assumes func_code is only meaningful when op_class[1] is set.
module alu_op_decoder
    import alu_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNC_W-1:0]  func_code,
    output alu_code_e          code,
    output logic               bad_func
);

    // Pick the ALU code from class first, then from the function field.
    always_comb begin
        bad_func = 1'b0;
        case (op_class)
            CLS_MEM:    code = ALU_ADD;
            CLS_BRANCH: code = ALU_SUB;
            default: begin
                case (func_code)
                    FN_ADD:  code = ALU_ADD;
                    FN_SUB:  code = ALU_SUB;
                    FN_AND:  code = ALU_AND;
                    FN_OR:   code = ALU_OR;
                    FN_SLT:  code = ALU_SLT;
                    default: begin
                        code     = ALU_ADD;
                        bad_func = 1'b1;
                    end
                endcase
            end
        endcase
    end

    // Guard: the error output only appears for register-format classes.
    always_comb begin
        if (bad_func) begin
            AST_BAD_ONLY_RFMT: assert (op_class[1] == 1'b1); // R8
        end
    end

endmodule

// File: rtl/alu_adder.sv
`timescale 1ns/1ps
// Module alu_adder
// Ripple adder shared by add, subtract and set-less-than. The invert input
// complements B and also supplies carry-in, so a + ~b + 1 = a - b.
// Also produces the raw signed overflow and the overflow-corrected sign,
// which is the less-than answer. Assumes W >= 2.
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         b_inv,
    output logic [W-1:0] sum,
    output logic         ovf_raw,
    output logic         less
);

    localparam int MSB = W - 1;

    logic carry_msb_in;
    logic carry_out;

    // Carry ripple from bit 0 to the MSB, keeping the carry into the MSB.
    always_comb begin
        logic c;
        logic bx;
        c            = b_inv;
        carry_msb_in = 1'b0;
        sum          = '0;
        for (int i = 0; i < W; i++) begin
            bx     = b[i] ^ b_inv;
            sum[i] = a[i] ^ bx ^ c;
            if (i == MSB) carry_msb_in = c;
            c = (a[i] & bx) | (c & (a[i] ^ bx));
        end
        carry_out = c;
    end

    // Signed overflow and the sign of the true difference.
    always_comb begin
        ovf_raw = carry_msb_in ^ carry_out;
        less    = sum[MSB] ^ ovf_raw;
    end

    // Guard: an overflowing sum has a sign unlike at least one operand.
    always_comb begin
        if (ovf_raw) begin
            AST_OVF_SIGN: assert (sum[MSB] != a[MSB]); // R7
        end
    end

endmodule

// File: rtl/alu_bit_select.sv
`timescale 1ns/1ps
// Module alu_bit_select
// One result bit: picks AND, OR, the adder sum bit or the less input.
// The AND and OR use the uninverted B, since only the adder sees the inversion.
// Assumes less is tied low for every bit except bit 0.
module alu_bit_select
    import alu_pkg::*;
(
    input  logic             a_bit,
    input  logic             b_bit,
    input  logic             sum_bit,
    input  logic             less_bit,
    input  logic [SEL_W-1:0] sel,
    output logic             res_bit
);

    // Four-way output select for this bit position.
    always_comb begin
        case (sel)
            SEL_AND: res_bit = a_bit & b_bit;
            SEL_OR:  res_bit = a_bit | b_bit;
            SEL_SUM: res_bit = sum_bit;
            default: res_bit = less_bit;
        endcase
    end

endmodule

// File: rtl/alu_flags.sv
`timescale 1ns/1ps
// Module alu_flags
// Status outputs: zero from the final result, and overflow gated so that
// only add and subtract report it. Assumes ovf_raw comes from the adder.
module alu_flags
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] result,
    input  alu_code_e    code,
    input  logic         ovf_raw,
    output logic         zero_flag,
    output logic         ovf_flag
);

    logic is_arith;

    // Zero detect over the whole result word.
    always_comb zero_flag = ~(|result);

    // Overflow is meaningful only for add and subtract.
    always_comb begin
        is_arith = (code == ALU_ADD) || (code == ALU_SUB);
        ovf_flag = ovf_raw & is_arith;
    end

endmodule

// File: rtl/arith_logic_unit.sv
`timescale 1ns/1ps
// Module arith_logic_unit
// Top of the ALU: operation decoder, shared ripple adder, per-bit output
// select and flag logic. Fully combinational; the caller registers outputs.
// Assumes DATA_W >= 2.
module arith_logic_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNC_W-1:0]  func_code,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    output logic [DATA_W-1:0]  result,
    output logic               zero_flag,
    output logic               ovf_flag,
    output logic               bad_func
);

    localparam int MSB = DATA_W - 1;

    alu_code_e         code;
    logic [DATA_W-1:0] sum;
    logic              ovf_raw;
    logic              less;
    logic [SEL_W-1:0]  sel;
    logic              b_inv;

    alu_op_decoder u_dec (
        .op_class (op_class),
        .func_code(func_code),
        .code     (code),
        .bad_func (bad_func)
    );

    // Split the code into adder control and output select.
    always_comb begin
        b_inv = code[CODE_W-1];
        sel   = code[SEL_W-1:0];
    end

    alu_adder #(.W(DATA_W)) u_add (
        .a      (opnd_a),
        .b      (opnd_b),
        .b_inv  (b_inv),
        .sum    (sum),
        .ovf_raw(ovf_raw),
        .less   (less)
    );

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            alu_bit_select u_sel (
                .a_bit   (opnd_a[i]),
                .b_bit   (opnd_b[i]),
                .sum_bit (sum[i]),
                .less_bit(less),
                .sel     (sel),
                .res_bit (result[i])
            );
        end else begin : g_upper
            alu_bit_select u_sel (
                .a_bit   (opnd_a[i]),
                .b_bit   (opnd_b[i]),
                .sum_bit (sum[i]),
                .less_bit(1'b0),
                .sel     (sel),
                .res_bit (result[i])
            );
        end
    end

    alu_flags #(.W(DATA_W)) u_flg (
        .result   (result),
        .code     (code),
        .ovf_raw  (ovf_raw),
        .zero_flag(zero_flag),
        .ovf_flag (ovf_flag)
    );

    // Port-level guards relating class, operands and outputs.
    always_comb begin
        if (op_class == CLS_MEM) begin
            AST_MEM_ADD: assert (result == opnd_a + opnd_b); // R1
        end
        if (op_class == CLS_BRANCH) begin
            AST_BRANCH_EQ: assert (zero_flag == (opnd_a == opnd_b)); // R2
        end
        if (op_class[1] && func_code == FN_SLT) begin
            AST_SLT_UPPER: assert (result[MSB:1] == '0); // R5
        end
        AST_ZERO_MATCH: assert (zero_flag == (result == '0)); // R6
        if (ovf_flag) begin
            AST_OVF_RESULT_SIGN: assert (result[MSB] != opnd_a[MSB]); // R7
        end
        if (bad_func) begin
            AST_BAD_AS_ADD: assert (result == opnd_a + opnd_b); // R8
        end
    end

endmodule

// File: tb/sim_arith_logic_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task applies a vector and queues the value
// the requirements predict; a monitor pops and compares at the falling edge.
module sim_arith_logic_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class = '0;
    logic [5:0]  func_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        zero_flag;
    logic        ovf_flag;
    logic        bad_func;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [31:0] r;
        logic        z;
        logic        o;
        logic        bd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    arith_logic_unit u0 (
        .op_class (op_class),
        .func_code(func_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .zero_flag(zero_flag),
        .ovf_flag (ovf_flag),
        .bad_func (bad_func)
    );

    // Reference model written from the requirements.
    function automatic exp_t predict(input logic [1:0] cls, input logic [5:0] fn,
                                     input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        int   op;
        e.bd = 1'b0;
        if (cls == 2'b00) op = 0;
        else if (cls == 2'b01) op = 1;
        else begin
            case (fn)
                6'h20: op = 0;
                6'h22: op = 1;
                6'h24: op = 2;
                6'h25: op = 3;
                6'h2A: op = 4;
                default: begin op = 0; e.bd = 1'b1; end
            endcase
        end
        e.o = 1'b0;
        case (op)
            0: begin
                e.r = a + b;
                e.o = (a[31] == b[31]) && (e.r[31] != a[31]);
            end
            1: begin
                e.r = a - b;
                e.o = (a[31] != b[31]) && (e.r[31] != a[31]);
            end
            2: e.r = a & b;
            3: e.r = a | b;
            default: e.r = {31'b0, ($signed(a) < $signed(b))};
        endcase
        e.z = (e.r == 32'b0);
        return e;
    endfunction

    task automatic drive(input logic [1:0] cls, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        @(posedge clk);
        #1;
        op_class  = cls;
        func_code = fn;
        opnd_a    = a;
        opnd_b    = b;
        exp_q.push_back(predict(cls, fn, a, b));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the outputs with the oldest queued prediction.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (result !== e.r || zero_flag !== e.z || ovf_flag !== e.o || bad_func !== e.bd) begin
                errs++;
                $display("FAIL %s: got r=%h z=%b o=%b bad=%b, expected r=%h z=%b o=%b bad=%b",
                         t, result, zero_flag, ovf_flag, bad_func, e.r, e.z, e.o, e.bd);
            end
        end
    end

    initial begin
        logic [31:0] s;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero inputs under class 00
        drive(2'b00, 6'h00, 32'h0, 32'h0, "R6 idle zero");
        // R1: memory class adds whatever the function field says
        drive(2'b00, 6'h22, 32'd5, 32'd3, "R1 class00 fn sub");
        drive(2'b00, 6'h3F, 32'h1234_0000, 32'h0000_5678, "R1 class00 fn 3F");
        drive(2'b00, 6'h24, 32'hFFFF_FFF0, 32'h0000_0020, "R1 class00 fn and");
        // R2: branch class subtracts
        drive(2'b01, 6'h20, 32'd7, 32'd7, "R2 branch equal");
        drive(2'b01, 6'h25, 32'd3, 32'd5, "R2 branch lower");
        // R3: each function code, both decode classes
        drive(2'b10, 6'h20, 32'd100, 32'd23, "R3 fn add");
        drive(2'b10, 6'h22, 32'd100, 32'd23, "R3 fn sub");
        drive(2'b10, 6'h24, 32'hF0F0_A5A5, 32'hFF00_0FF0, "R3 fn and");
        drive(2'b10, 6'h25, 32'hF0F0_A5A5, 32'h0F00_0FF0, "R3 fn or");
        drive(2'b10, 6'h2A, 32'd4, 32'd9, "R3 fn slt");
        drive(2'b11, 6'h24, 32'h0000_FFFF, 32'h00FF_00FF, "R3 class11 and");
        drive(2'b11, 6'h22, 32'd9, 32'd4, "R3 class11 sub");
        // R4: wrap-around
        drive(2'b10, 6'h20, 32'hFFFF_FFFF, 32'h1, "R4 add wrap");
        drive(2'b10, 6'h22, 32'h0, 32'h1, "R4 sub borrow");
        // R5: signed less-than, including overflowing differences
        drive(2'b10, 6'h2A, 32'hFFFF_FFFF, 32'h1, "R5 -1<1");
        drive(2'b10, 6'h2A, 32'h1, 32'hFFFF_FFFF, "R5 1<-1");
        drive(2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, "R5 min<max");
        drive(2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000, "R5 max<min");
        drive(2'b10, 6'h2A, 32'h8000_0000, 32'h8000_0000, "R5 equal");
        // R7: overflow only for add/sub
        drive(2'b10, 6'h20, 32'h7FFF_FFFF, 32'h1, "R7 add ovf");
        drive(2'b10, 6'h20, 32'h8000_0000, 32'h8000_0000, "R7 add neg ovf");
        drive(2'b10, 6'h22, 32'h8000_0000, 32'h1, "R7 sub ovf");
        drive(2'b10, 6'h22, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R7 sub pos ovf");
        drive(2'b10, 6'h24, 32'h7FFF_FFFF, 32'h1, "R7 and no ovf");
        drive(2'b10, 6'h25, 32'h8000_0000, 32'h8000_0000, "R7 or no ovf");
        drive(2'b10, 6'h2A, 32'h8000_0000, 32'h1, "R7 slt no ovf");
        // R8: unknown function fields
        drive(2'b10, 6'h00, 32'd10, 32'd20, "R8 fn 00 default");
        drive(2'b11, 6'h3F, 32'h7FFF_FFFF, 32'h1, "R8 fn 3F add ovf");
        drive(2'b10, 6'h21, 32'd1, 32'd2, "R8 fn 21");
        drive(2'b01, 6'h00, 32'd1, 32'd2, "R8 no flag class01");
        // Mixed pseudo-random coverage of all paths
        s = 32'h1ACE_B00C;
        for (int k = 0; k < 60; k++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            logic [5:0]  fn;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            ra = s;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            rb = (k % 7 == 0) ? ra : s;
            case (k % 6)
                0: fn = 6'h20;
                1: fn = 6'h22;
                2: fn = 6'h24;
                3: fn = 6'h25;
                4: fn = 6'h2A;
                default: fn = s[13:8];
            endcase
            drive(s[1:0], fn, ra, rb, "R3 R4 R5 R7 mixed");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule